// File: doc/BRIEF.md
# Bouncing LED Scanner with Fading Trail

This block drives a row of LEDs with a back-and-forth scanning pattern that shows the chip is alive. A single lit position steps along the row one LED per step period. It runs from the first LED to the last and back again, and keeps doing so. The LED under the lit position is held fully on. Every LED the position has passed fades out gradually.

Each LED keeps a brightness level. The level is refilled to full while that LED is the lit position. After the position moves on, the level shrinks by roughly one eighth on every decay tick. A first-order accumulator turns the level into a pulse-density stream.

A processor can write a mask register and a value register through a small write port. These replace the pattern on any chosen LEDs. A per-LED polarity mask, set at build time, inverts the outputs that are wired active-low. By default these are LEDs 6 and 7. The inversion is applied after the override.

Top module: `led_sweep_trail`

## Requirements
- R1: The lit position starts at LED 0 and changes only on a step tick, always to an adjacent LED. It ascends to LED N-1 and then descends to LED 0.
- R2: Each end is visited once per turn. Position N-1 is followed by N-2, and position 0 is followed by 1.
- R3: While not overridden, the output of the LED at the lit position shows "on" in every clock cycle.
- R4: For a LED that is not at the lit position and whose level L stays constant, the LED is on in exactly L cycles out of any 256 consecutive cycles.
- R5: A LED's level is loaded with 255 in every cycle in which it is the lit position. On each decay tick a level L that is not zero becomes L - max(L>>3, 1). The level never rises otherwise and settles at 0.
- R6: A LED that the position has just left is pulsed and not held fully on. Once its level has decayed, the LED is dark.
- R7: A write with `wr_en` high stores `wr_data` in the override mask when `wr_sel` = 0, and in the override value when `wr_sel` = 1. Every LED whose mask bit is 1 shows its value bit instead of the pattern.
- R8: Each output equals its logical "on" state XORed with `INV_MASK`, which defaults to 8'hC0. The XOR is applied after the override.
- R9: While `rst_n` is low, the lit position is 0 and ascending, all levels are 0, and the override mask is clear. With the default parameters, `led_o` therefore reads 8'hC1 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 1 | Register select: 0 = override mask, 1 = override value |
| wr_data | input | N_LEDS | Data written to the selected register |
| led_o | output | N_LEDS | LED pins after override and polarity inversion |

## Verification
The assertions assume that `rst_n` is held low long enough to reach the internal synchronizer. They also assume the override mask is zero whenever the lit LED is expected to be fully on.

The stimulus resets the block before each scenario. It writes the override registers only in the override scenario and clears them by reset. The fade scenarios use short step and decay dividers so that whole fades fit in a short run.

// File: rtl/led_sweep_pkg.sv
package led_sweep_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} sweep_dir_e;
  localparam logic SEL_MASK  = 1'b0;
  localparam logic SEL_VALUE = 1'b1;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import led_sweep_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] pos,
  output logic [N-1:0]  active
);
  localparam logic [PW-1:0] TOP = PW'(N - 1);

  logic [PW-1:0] pos_q, pos_d;
  sweep_dir_e    dir_q, dir_d;

  always_comb begin
    pos_d = pos_q;
    dir_d = dir_q;
    if (step) begin
      if (dir_q == DIR_UP) begin
        if (pos_q == TOP) begin
          pos_d = pos_q - 1'b1;
          dir_d = DIR_DOWN;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end else begin
        if (pos_q == '0) begin
          pos_d = pos_q + 1'b1;
          dir_d = DIR_UP;
        end else begin
          pos_d = pos_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      pos_q <= pos_d;
      dir_q <= dir_d;
    end
  end

  assign pos = pos_q;

  for (genvar i = 0; i < N; i++) begin : g_act
    assign active[i] = (pos_q == PW'(i));
  end
endmodule

// File: rtl/trail_cell.sv
module trail_cell #(
  parameter int unsigned LW    = 8,
  parameter int unsigned SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          decay,
  output logic [LW-1:0] level,
  output logic          lit
);
  logic [LW-1:0] lvl_q, lvl_d, dec;
  logic [LW-1:0] acc_q, acc_d;
  logic          pdm_q, pdm_d;
  logic [LW:0]   sum;

  always_comb begin
    dec = lvl_q >> SHIFT;
    if (dec == '0) dec = LW'(1);
    lvl_d = lvl_q;
    if (active)                      lvl_d = '1;
    else if (decay && lvl_q != '0)   lvl_d = lvl_q - dec;
  end

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, lvl_q};
    acc_d = sum[LW-1:0];
    pdm_d = sum[LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      acc_q <= '0;
      pdm_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      acc_q <= acc_d;
      pdm_q <= pdm_d;
    end
  end

  assign level = lvl_q;
  assign lit   = active | pdm_q;
endmodule

// File: rtl/led_sweep_trail.sv
module led_sweep_trail
  import led_sweep_pkg::*;
#(
  parameter int unsigned N_LEDS      = 8,
  parameter int unsigned LVL_W       = 8,
  parameter int unsigned DECAY_SHIFT = 3,
  parameter int unsigned STEP_DIV    = 6_250_000,
  parameter int unsigned DECAY_DIV   = 1_000_000,
  parameter logic [N_LEDS-1:0] INV_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [N_LEDS-1:0] wr_data,
  output logic [N_LEDS-1:0] led_o
);
  localparam int unsigned PW = (N_LEDS > 1) ? $clog2(N_LEDS) : 1;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic step_tick, decay_tick;

  tick_div #(.DIV(STEP_DIV)) i_step_div (
    .clk(clk), .rst_n(rst_sync_n), .tick(step_tick)
  );
  tick_div #(.DIV(DECAY_DIV)) i_decay_div (
    .clk(clk), .rst_n(rst_sync_n), .tick(decay_tick)
  );

  logic [PW-1:0]     pos;
  logic [N_LEDS-1:0] active;

  sweep_seq #(.N(N_LEDS)) i_seq (
    .clk(clk), .rst_n(rst_sync_n), .step(step_tick),
    .pos(pos), .active(active)
  );

  logic [N_LEDS-1:0]       lit;
  logic [N_LEDS*LVL_W-1:0] lvl_flat;

  for (genvar i = 0; i < N_LEDS; i++) begin : g_cell
    trail_cell #(.LW(LVL_W), .SHIFT(DECAY_SHIFT)) i_cell (
      .clk(clk), .rst_n(rst_sync_n),
      .active(active[i]), .decay(decay_tick),
      .level(lvl_flat[i*LVL_W +: LVL_W]), .lit(lit[i])
    );
  end

  logic [N_LEDS-1:0] ovr_mask_q, ovr_mask_d;
  logic [N_LEDS-1:0] ovr_val_q, ovr_val_d;

  always_comb begin
    ovr_mask_d = ovr_mask_q;
    ovr_val_d  = ovr_val_q;
    if (wr_en) begin
      if (wr_sel == SEL_MASK) ovr_mask_d = wr_data;
      else                    ovr_val_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovr_mask_q <= '0;
      ovr_val_q  <= '0;
    end else begin
      ovr_mask_q <= ovr_mask_d;
      ovr_val_q  <= ovr_val_d;
    end
  end

  logic [N_LEDS-1:0] led_on;
  assign led_on = (ovr_mask_q & ovr_val_q) | (~ovr_mask_q & lit);
  assign led_o  = led_on ^ INV_MASK;
endmodule

// File: rtl/led_sweep_trail_chk.sv
module led_sweep_trail_chk #(
  parameter int unsigned N   = 8,
  parameter int unsigned LW  = 8,
  parameter logic [N-1:0] INV = 8'hC0,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          step_tick,
  input logic [PW-1:0] pos,
  input logic [N*LW-1:0] lvl_flat,
  input logic [N-1:0]  ovr_mask_q,
  input logic [N-1:0]  ovr_val_q,
  input logic [N-1:0]  led_o
);
  logic [N-1:0] seen_on;
  assign seen_on = led_o ^ INV;

  assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(pos) < N);

  assert_step_adjacent_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_tick |=> ((int'(pos) == int'($past(pos)) + 1) || (int'(pos) + 1 == int'($past(pos)))));

  assert_hold_between_steps_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !step_tick |=> $stable(pos));

  assert_top_turn_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_tick && int'(pos) == N-1) |=> int'(pos) == N-2);

  assert_bottom_turn_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_tick && pos == '0) |=> int'(pos) == 1);

  assert_active_full_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovr_mask_q == '0) |-> seen_on[pos]);

  for (genvar i = 0; i < N; i++) begin : g_lvl
    assert_active_loads_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pos == PW'(i)) |=> (lvl_flat[i*LW +: LW] == {LW{1'b1}}));
    assert_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pos != PW'(i)) |=> (lvl_flat[i*LW +: LW] <= $past(lvl_flat[i*LW +: LW])));
  end

  assert_full_override_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovr_mask_q == '1) |-> (led_o == (ovr_val_q ^ INV)));
endmodule

bind led_sweep_trail led_sweep_trail_chk #(.N(N_LEDS), .LW(LVL_W), .INV(INV_MASK)) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .step_tick(step_tick), .pos(pos),
  .lvl_flat(lvl_flat), .ovr_mask_q(ovr_mask_q), .ovr_val_q(ovr_val_q), .led_o(led_o)
);

// File: tb/test_led_sweep_trail.sv
module test_led_sweep_trail;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] led_fast, led_slow;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  led_sweep_trail #(.STEP_DIV(64), .DECAY_DIV(1)) i_led_sweep_trail (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .led_o(led_fast)
  );

  led_sweep_trail #(.STEP_DIV(4096), .DECAY_DIV(1024)) i_led_sweep_trail_slow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .led_o(led_slow)
  );

  wire [7:0] pat_fast = led_fast ^ 8'hC0;
  wire [7:0] pat_slow = led_slow ^ 8'hC0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL timeout on all requirements actual %0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  function automatic int pos_at(int k);
    int p = (k + 1) % 14;
    return (p <= 7) ? p : 14 - p;
  endfunction

  function automatic int level_after(int k);
    int l = 255;
    for (int j = 0; j < k; j++) begin
      if (l != 0) l = l - (((l >> 3) == 0) ? 1 : (l >> 3));
    end
    return l;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset pins fast", led_fast, 8'hC1);
    chk("R9 reset pins slow", led_slow, 8'hC1);
    rst_n = 1'b1;
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic test_density();
    do_reset();
    while (pat_slow[1] !== 1'b1) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      int ones = 0;
      repeat (100) @(negedge clk);
      for (int c = 0; c < 256; c++) begin
        if (pat_slow[0]) ones++;
        @(negedge clk);
      end
      chk((k < 3) ? "R4 density equals level" : "R5 decay level", ones, level_after(k));
      repeat (1024 - 356) @(negedge clk);
    end
  endtask

  task automatic test_sweep();
    int miss = 0;
    int trail = 0;
    do_reset();
    while (pat_fast[1] !== 1'b1) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < 64; c++) begin
        if (!(k == 0 && c == 0)) @(negedge clk);
        if (!pat_fast[pos_at(k)]) miss++;
        if (k == 0 && c >= 1 && c <= 8 && pat_fast[0]) trail++;
        if (c == 56) chk("R1 R2 lit position late in step", pat_fast, 1 << pos_at(k));
      end
    end
    chk("R3 lit LED never off", miss, 0);
    chk("R6 left LED pulsed at least 3 of 8", int'(trail >= 3), 1);
    chk("R6 left LED not fully on", int'(trail < 8), 1);
  endtask

  task automatic test_override();
    int bad = 0;
    do_reset();
    repeat (10) @(negedge clk);
    write_reg(1'b1, 8'hA5);
    write_reg(1'b0, 8'hFF);
    chk("R7 R8 full override pins", led_fast, 8'h65);
    write_reg(1'b1, 8'h00);
    chk("R8 inversion after override", led_fast, 8'hC0);
    write_reg(1'b1, 8'h05);
    write_reg(1'b0, 8'h0F);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if ((pat_fast & 8'h0F) != 8'h05) bad++;
    end
    chk("R7 partial mask low nibble", bad, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 async reset clears override", led_fast, 8'hC1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 mask clear after release", led_fast, 8'hC1);
  endtask

  initial begin
    test_density();
    test_sweep();
    test_override();
    done = 1;
    summary();
    $finish;
  end
endmodule